// File: doc/BRIEF.md
# Per-Lane Serial Link Bit Error Rate Test Engine

This block is one lane of a serial-link bit error rate tester. The generator half turns a selected test pattern into 10-bit parallel symbols for the serializer. The checker half compares the 10-bit symbols coming back from the deserializer against the same pattern. It follows the incoming pseudo-random stream on its own, reports when it has locked onto it, and counts the bit errors it sees while locked. A chip builds one instance per lane. The test streams carry no framing, so they pass neither the line encoder nor the word aligner. Receive word alignment must be switched off while a test runs.

A 2-bit mode input picks the pattern. The choices are off, a 15th-order pseudo-random sequence, a 7th-order pseudo-random sequence, or a programmable 10-bit symbol sent over and over. The pseudo-random generator advances its shift register by ten steps each clock. Whenever the mode changes, the register restarts from an all-ones seed. In the pseudo-random modes the checker acquires by loading its own register from the received bits. Once locked, it runs freely, so each flipped line bit is counted exactly once.

Top module: `bert_lane`

## Requirements
- R1: With `test_mode` = 0, `tx_sym` is held at the idle symbol 10'h000 from the clock after the mode is sampled. `rx_locked` is 0 and `bit_err_cnt` holds its value.
- R2: With `test_mode` = 1, each serial bit is b = s[14] ^ s[13]. It is shifted into s at bit 0 and also sent. Bit i of a symbol is the i-th bit sent in time. Ten bits form one symbol per clock, and s starts at all ones.
- R3: With `test_mode` = 2, the same scheme uses b = s[6] ^ s[5], so the symbol stream repeats every 127 symbols.
- R4: With `test_mode` = 3, `tx_sym` equals the `fixed_pat` value sampled at the previous clock edge.
- R5: Every change of `test_mode` reseeds the generator and the checker register to all ones. Returning to a mode restarts its sequence from the first symbol.
- R6: The checker compares one symbol per clock. It skips the edge at which the mode changes and all edges in mode 0. `rx_locked` rises at the edge that checks the 32nd consecutive error-free symbol.
- R7: While locked, `rx_locked` falls at the edge that checks the 8th consecutive symbol containing an error. Seven errored symbols followed by a clean one keep lock.
- R8: For every symbol checked while locked, `bit_err_cnt` grows by the number of differing bits. Symbols checked while unlocked add nothing.
- R9: `bit_err_cnt` saturates at its all-ones value and never wraps.
- R10: `cnt_clr` high at an edge sets `bit_err_cnt` to 0 and overrides any error counted at that edge.
- R11: In mode 3 each received symbol is compared directly with `fixed_pat`, with no rotation search. A rotated copy of the pattern counts as errors.
- R12: A mode change drops `rx_locked` at that edge and leaves `bit_err_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock, one symbol per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 2 | 0 off, 1 PRBS15, 2 PRBS7, 3 fixed symbol |
| fixed_pat | input | 10 | Symbol sent and expected in mode 3 |
| cnt_clr | input | 1 | Clears the error counter |
| rx_sym | input | 10 | Received symbol, bit 0 earliest |
| tx_sym | output | 10 | Generated symbol, bit 0 earliest |
| rx_locked | output | 1 | Checker is locked to the received pattern |
| bit_err_cnt | output | CNT_W | Saturating count of bit errors while locked |

## Verification
The bench runs the lane in loopback and checks the lock threshold at its exact edge, 31 clean symbols against 32. A checker that started comparing at the mode-change edge, or that used an off-by-one counter, would move lock by a cycle. It injects runs of seven and eight errored symbols to pin the unlock rule. It also checks that errors arriving while unlocked are not counted, which a design without that gating would add to the count. An 8-bit counter configuration drives the count past all ones, where a design without saturation would wrap. In fixed mode, a rotated copy of the pattern must count as errors. A design that searched rotations would report zero.

// File: rtl/bert_pkg.sv
// Shared types and pattern arithmetic for the lane test engine.
// Assumes 10-bit symbols whose bit 0 is the earliest serial bit.
package bert_pkg;

    localparam int SYM_W = 10;
    localparam int ST_W  = 15;
    localparam int POP_W = $clog2(SYM_W + 1);

    typedef enum logic [1:0] {
        BM_OFF = 2'd0,
        BM_P15 = 2'd1,
        BM_P7  = 2'd2,
        BM_FIX = 2'd3
    } bert_mode_e;

    typedef struct packed {
        logic [ST_W-1:0]  st;
        logic [SYM_W-1:0] bits;
    } prbs_res_t;

    localparam logic [ST_W-1:0] SEED = '1;

    // Advance the shift register by one symbol of serial bits.
    function automatic prbs_res_t prbs_step(input logic [ST_W-1:0] s_in,
                                            input bert_mode_e m);
        prbs_res_t r;
        logic [ST_W-1:0] s;
        logic fb;
        s = s_in;
        r.bits = '0;
        for (int i = 0; i < SYM_W; i++) begin
            fb = (m == BM_P7) ? (s[6] ^ s[5]) : (s[14] ^ s[13]);
            r.bits[i] = fb;
            s = {s[ST_W-2:0], fb};
        end
        r.st = s;
        return r;
    endfunction

    // Shift the received symbol into the register, earliest bit first.
    function automatic logic [ST_W-1:0] prbs_load(input logic [ST_W-1:0] s_in,
                                                  input logic [SYM_W-1:0] rx);
        logic [ST_W-1:0] s;
        s = s_in;
        for (int i = 0; i < SYM_W; i++) begin
            s = {s[ST_W-2:0], rx[i]};
        end
        return s;
    endfunction

    // Number of set bits in a symbol.
    function automatic logic [POP_W-1:0] popcnt(input logic [SYM_W-1:0] v);
        logic [POP_W-1:0] c;
        c = '0;
        for (int i = 0; i < SYM_W; i++) begin
            c = c + POP_W'(v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/bert_gen.sv
// Pattern generator: registered symbol output for the serializer.
// Assumes mode_chg is high in the first cycle a new mode is presented.
module bert_gen
    import bert_pkg::*;
#(
    parameter logic [SYM_W-1:0] IDLE_SYM = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bert_mode_e       mode,
    input  logic             mode_chg,
    input  logic [SYM_W-1:0] pat,
    output logic [SYM_W-1:0] tx_sym
);

    logic [ST_W-1:0] st;
    logic [ST_W-1:0] cur;
    prbs_res_t       nxt;

    // Pick the register value this cycle starts from, reseeded on a mode change.
    always_comb begin
        cur = mode_chg ? SEED : st;
        nxt = prbs_step(cur, mode);
    end

    // Produce one symbol per clock for the selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SEED;
            tx_sym <= IDLE_SYM;
        end else begin
            case (mode)
                BM_P15, BM_P7: begin
                    st     <= nxt.st;
                    tx_sym <= nxt.bits;
                end
                BM_FIX: begin
                    st     <= SEED;
                    tx_sym <= pat;
                end
                default: begin
                    st     <= SEED;
                    tx_sym <= IDLE_SYM;
                end
            endcase
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BM_OFF) |=> (tx_sym == IDLE_SYM)); // R1
    AST_FIXED_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BM_FIX) |=> (tx_sym == $past(pat))); // R4
    AST_STATE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BM_P7) |=> (st[6:0] != '0)); // R3
    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st != '0)); // R5

endmodule

// File: rtl/bert_chk.sv
// Pattern checker: predicts each received symbol and returns the bits that differ.
// Acquires by loading from received data while unlocked and runs freely once locked.
module bert_chk
    import bert_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  bert_mode_e       mode,
    input  logic             mode_chg,
    input  logic             locked,
    input  logic [SYM_W-1:0] pat,
    input  logic [SYM_W-1:0] rx_sym,
    output logic             cmp_vld,
    output logic [SYM_W-1:0] err_bits
);

    logic [ST_W-1:0] st;
    prbs_res_t       pred;
    logic            is_prbs;

    // Form the expected symbol and the error mask for this cycle.
    always_comb begin
        is_prbs  = (mode == BM_P15) || (mode == BM_P7);
        pred     = prbs_step(st, mode);
        cmp_vld  = (mode != BM_OFF) && !mode_chg;
        if (!cmp_vld) begin
            err_bits = '0;
        end else if (mode == BM_FIX) begin
            err_bits = rx_sym ^ pat;
        end else begin
            err_bits = rx_sym ^ pred.bits;
        end
    end

    // Track the sequence: reseed, load from the line, or run freely.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SEED;
        end else if (mode_chg || !is_prbs) begin
            st <= SEED;
        end else if (locked) begin
            st <= pred.st;
        end else begin
            st <= prbs_load(st, rx_sym);
        end
    end

    AST_SKIP_CHANGE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (err_bits == '0)); // R6

endmodule

// File: rtl/bert_lock.sv
// Lock tracking and saturating bit error counter.
// Assumes err_bits is zero whenever cmp_vld is low.
module bert_lock
    import bert_pkg::*;
#(
    parameter int LOCK_N   = 32,
    parameter int UNLOCK_N = 8,
    parameter int CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_vld,
    input  logic [SYM_W-1:0] err_bits,
    input  logic             cnt_clr,
    output logic             locked,
    output logic [CNT_W-1:0] err_cnt
);

    localparam int GOOD_W = $clog2(LOCK_N);
    localparam int BAD_W  = $clog2(UNLOCK_N);

    logic [GOOD_W-1:0] good_run;
    logic [BAD_W-1:0]  bad_run;
    logic              err_any;
    logic [CNT_W:0]    sum;

    // Flag an errored symbol and form the unsaturated new count.
    always_comb begin
        err_any = |err_bits;
        sum     = {1'b0, err_cnt} + (CNT_W + 1)'(popcnt(err_bits));
    end

    // Count clean runs to lock and errored runs to unlock.
    always_ff @(posedge clk) begin
        if (!rst_n || !cmp_vld) begin
            locked   <= 1'b0;
            good_run <= '0;
            bad_run  <= '0;
        end else if (!locked) begin
            bad_run <= '0;
            if (err_any) begin
                good_run <= '0;
            end else if (good_run == GOOD_W'(LOCK_N - 1)) begin
                good_run <= '0;
                locked   <= 1'b1;
            end else begin
                good_run <= good_run + 1'b1;
            end
        end else begin
            good_run <= '0;
            if (!err_any) begin
                bad_run <= '0;
            end else if (bad_run == BAD_W'(UNLOCK_N - 1)) begin
                bad_run <= '0;
                locked  <= 1'b0;
            end else begin
                bad_run <= bad_run + 1'b1;
            end
        end
    end

    // Accumulate errors while locked, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            err_cnt <= '0;
        end else if (locked && cmp_vld) begin
            err_cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (err_cnt >= $past(err_cnt))); // R9
    AST_UNLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !cnt_clr) |=> $stable(err_cnt)); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (err_cnt == '0)); // R10
    AST_CLEAN_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cmp_vld && !err_any) |=> locked); // R7

endmodule

// File: rtl/bert_lane.sv
// One lane of the bit error rate test engine: generator plus checker.
// Assumes receive word alignment is off and rx_sym is raw deserializer output.
module bert_lane
    import bert_pkg::*;
#(
    parameter logic [9:0] IDLE_SYM = 10'h000,
    parameter int         LOCK_N   = 32,
    parameter int         UNLOCK_N = 8,
    parameter int         CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       test_mode,
    input  logic [9:0]       fixed_pat,
    input  logic             cnt_clr,
    input  logic [9:0]       rx_sym,
    output logic [9:0]       tx_sym,
    output logic             rx_locked,
    output logic [CNT_W-1:0] bit_err_cnt
);

    bert_mode_e       mode;
    bert_mode_e       mode_q;
    logic             mode_chg;
    logic             cmp_vld;
    logic [SYM_W-1:0] err_bits;

    // Decode the mode and detect a change against the previous cycle.
    always_comb begin
        mode     = bert_mode_e'(test_mode);
        mode_chg = (mode != mode_q);
    end

    // Remember the mode of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= BM_OFF;
        end else begin
            mode_q <= mode;
        end
    end

    bert_gen #(.IDLE_SYM(IDLE_SYM)) i_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .mode_chg (mode_chg),
        .pat      (fixed_pat),
        .tx_sym   (tx_sym)
    );

    bert_chk i_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .mode_chg (mode_chg),
        .locked   (rx_locked),
        .pat      (fixed_pat),
        .rx_sym   (rx_sym),
        .cmp_vld  (cmp_vld),
        .err_bits (err_bits)
    );

    bert_lock #(
        .LOCK_N   (LOCK_N),
        .UNLOCK_N (UNLOCK_N),
        .CNT_W    (CNT_W)
    ) i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_vld  (cmp_vld),
        .err_bits (err_bits),
        .cnt_clr  (cnt_clr),
        .locked   (rx_locked),
        .err_cnt  (bit_err_cnt)
    );

    AST_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BM_OFF) |=> !rx_locked); // R1
    AST_CHANGE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !rx_locked); // R12
    AST_CHANGE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && !cnt_clr) |=> $stable(bit_err_cnt)); // R12

endmodule

// File: tb/test_bert_lane.sv
// Bench for bert_lane with an 8-bit error counter. Inputs change at the falling edge.
module test_bert_lane;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    test_mode = 2'd0;
    logic [9:0]    fixed_pat = 10'h000;
    logic          cnt_clr = 1'b0;
    logic [9:0]    tx_sym;
    logic          rx_locked;
    logic [CW-1:0] bit_err_cnt;
    logic          loop_en = 1'b0;
    logic [9:0]    inj = 10'h000;
    logic [9:0]    rx_drv = 10'h000;
    logic [9:0]    rx_sym;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign rx_sym = loop_en ? (tx_sym ^ inj) : rx_drv;

    bert_lane #(.CNT_W(CW)) i_bert_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_mode   (test_mode),
        .fixed_pat   (fixed_pat),
        .cnt_clr     (cnt_clr),
        .rx_sym      (rx_sym),
        .tx_sym      (tx_sym),
        .rx_locked   (rx_locked),
        .bit_err_cnt (bit_err_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Serial model: tap positions from the polynomial degree.
    function automatic logic [9:0] model(inout logic [14:0] s, input int deg);
        logic [9:0] r;
        logic fb;
        for (int i = 0; i < 10; i++) begin
            fb = s[deg-1] ^ s[deg-2];
            r[i] = fb;
            s = {s[13:0], fb};
        end
        return r;
    endfunction

    function automatic int ones(input logic [9:0] v);
        int n = 0;
        for (int i = 0; i < 10; i++) n += v[i];
        return n;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [14:0] ms;
        logic [9:0] hist [0:253];
        logic [9:0] e;
        int exp_cnt;
        int bad;

        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(tx_sym == 10'h000, "R1 reset tx", tx_sym, 0);
        check(!rx_locked, "R1 reset lock", rx_locked, 0);
        check(bit_err_cnt == 0, "R1 reset count", bit_err_cnt, 0);

        // R2 and R6: PRBS15 loopback, exact lock edge.
        test_mode = 2'd1; loop_en = 1'b1; ms = '1; bad = 0;
        for (int k = 0; k < 60; k++) begin
            step();
            e = model(ms, 15);
            if (tx_sym != e) bad++;
            if (k == 31) check(!rx_locked, "R6 no lock at 31", rx_locked, 0);
            if (k == 32) check(rx_locked, "R6 lock at 32", rx_locked, 1);
        end
        check(bad == 0, "R2 prbs15 stream", bad, 0);

        // R8: exact bit counts while locked.
        inj = 10'b0000100101; step(); inj = '0; step();
        check(bit_err_cnt == 3, "R8 three bit errors", bit_err_cnt, 3);
        inj = 10'h3FF; step(); inj = '0; step();
        check(bit_err_cnt == 13, "R8 full symbol error", bit_err_cnt, 13);

        // R7: seven errored symbols keep lock, eight drop it.
        inj = 10'h001; repeat (7) step(); inj = '0; step();
        check(rx_locked, "R7 seven keep lock", rx_locked, 1);
        check(bit_err_cnt == 20, "R8 count after seven", bit_err_cnt, 20);
        inj = 10'h001; repeat (7) step();
        check(rx_locked, "R7 still locked at seven", rx_locked, 1);
        step();
        check(!rx_locked, "R7 unlock at eight", rx_locked, 0);
        check(bit_err_cnt == 28, "R8 count at unlock", bit_err_cnt, 28);
        inj = 10'h3FF; repeat (5) step(); inj = '0;
        check(bit_err_cnt == 28, "R8 unlocked not counted", bit_err_cnt, 28);
        repeat (40) step();
        check(rx_locked, "R6 reacquire", rx_locked, 1);
        check(bit_err_cnt == 28, "R8 no count during reacquire", bit_err_cnt, 28);

        // R10: clear beats a same-cycle error.
        cnt_clr = 1'b1; inj = 10'h003; step(); cnt_clr = 1'b0; inj = '0;
        check(bit_err_cnt == 0, "R10 clear priority", bit_err_cnt, 0);
        inj = 10'h006; step(); inj = '0; step();
        check(bit_err_cnt == 2, "R8 count after clear", bit_err_cnt, 2);

        // R3, R12: PRBS7, period and lock drop on change.
        test_mode = 2'd2; ms = '1; bad = 0;
        for (int k = 0; k < 254; k++) begin
            step();
            hist[k] = tx_sym;
            e = model(ms, 7);
            if (tx_sym != e) bad++;
            if (k == 0) check(!rx_locked, "R12 lock dropped", rx_locked, 0);
            if (k == 0) check(bit_err_cnt == 2, "R12 count kept", bit_err_cnt, 2);
            if (k == 32) check(rx_locked, "R6 prbs7 lock", rx_locked, 1);
        end
        check(bad == 0, "R3 prbs7 stream", bad, 0);
        bad = 0;
        for (int k = 0; k < 127; k++) if (hist[k] != hist[k+127]) bad++;
        check(bad == 0, "R3 period 127", bad, 0);
        check(bit_err_cnt == 2, "R12 clean after change", bit_err_cnt, 2);

        // R5: returning to PRBS15 restarts from the seed.
        test_mode = 2'd1; ms = '1; bad = 0;
        for (int k = 0; k < 20; k++) begin
            step();
            e = model(ms, 15);
            if (tx_sym != e) bad++;
        end
        check(bad == 0, "R5 reseed restart", bad, 0);

        // R4, R11: fixed symbol, direct compare.
        test_mode = 2'd3; fixed_pat = 10'h2A5; loop_en = 1'b0; rx_drv = 10'h2A5;
        cnt_clr = 1'b1; step(); cnt_clr = 1'b0; bad = 0;
        if (tx_sym != 10'h2A5) bad++;
        for (int k = 1; k < 40; k++) begin
            step();
            if (tx_sym != 10'h2A5) bad++;
            if (k == 31) check(!rx_locked, "R6 fixed no lock at 31", rx_locked, 0);
            if (k == 32) check(rx_locked, "R6 fixed lock at 32", rx_locked, 1);
        end
        check(bad == 0, "R4 fixed stream", bad, 0);
        exp_cnt = 0;
        rx_drv = 10'h2A5 ^ 10'h003; step(); rx_drv = 10'h2A5; exp_cnt += 2;
        rx_drv = {fixed_pat[8:0], fixed_pat[9]}; exp_cnt += ones(rx_drv ^ fixed_pat);
        step(); rx_drv = 10'h2A5; step();
        check(bit_err_cnt == CW'(exp_cnt), "R11 rotation counted", bit_err_cnt, exp_cnt);
        fixed_pat = 10'h1C3; rx_drv = 10'h1C3; step();
        check(tx_sym == 10'h1C3, "R4 new pattern", tx_sym, 10'h1C3);
        step();
        check(bit_err_cnt == CW'(exp_cnt), "R11 new pattern compared", bit_err_cnt, exp_cnt);

        // R9: saturation of the 8-bit counter.
        for (int b = 0; b < 4; b++) begin
            rx_drv = ~fixed_pat; repeat (7) step(); rx_drv = fixed_pat; step();
            exp_cnt += 70;
            if (b == 1) check(bit_err_cnt == CW'(exp_cnt), "R9 below limit", bit_err_cnt, exp_cnt);
        end
        check(bit_err_cnt == 8'hFF, "R9 saturated", bit_err_cnt, 8'hFF);
        check(rx_locked, "R7 lock kept across blocks", rx_locked, 1);
        rx_drv = ~fixed_pat; step(); rx_drv = fixed_pat; step();
        check(bit_err_cnt == 8'hFF, "R9 no wrap", bit_err_cnt, 8'hFF);

        // R1: off mode.
        test_mode = 2'd0; bad = 0;
        for (int k = 0; k < 10; k++) begin
            step();
            if (tx_sym != 10'h000 || rx_locked) bad++;
        end
        check(bad == 0, "R1 idle and unlocked", bad, 0);
        check(bit_err_cnt == 8'hFF, "R1 count held", bit_err_cnt, 8'hFF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule